// File: doc/BRIEF.md
# I2C Master Command and Acknowledge Control

This unit sits between a software register interface and the bit-level engine of an I2C master. Software writes a control word that holds an acknowledge-choice bit, a two-bit command field and a smart-mode enable. The unit turns that word into single-cycle requests for the bit engine: drive ACK, drive NACK, issue a repeated start, fetch the next byte, or issue a stop. The bit engine raises a master-on-bus or slave-on-bus event whenever it waits for software. A command is honoured only while one of those pending flags is held, and an honoured command consumes both flags.

The acknowledge choice can be applied in two ways. Software can write a command, or, with smart mode on, it can read the received-data register, which then acts like a fetch-next-byte command. The unit keeps the current transfer direction, which the bit engine loads after each address phase. The acknowledge choice only matters in master read mode. In write mode only a repeated start or a stop can come from a command.

Top module: `i2c_cmd_ctrl`

## Requirements
- R1: After reset the control word reads back as zero (ACK chosen, smart mode off), both pending flags are 0, the reported mode is write, and no request is raised.
- R2: Control readback, selected by `rd_sel`=0, puts the acknowledge choice on bit 3 and smart mode on bit 0. Bits 2:1, the command field, always read 0, even just after a command write. `rd_sel`=1 returns `rx_byte`.
- R3: A control write updates the acknowledge choice and smart mode on the next clock, in any state, including when the command in the same write is rejected.
- R4: A write with a nonzero command while both pending flags are 0 raises no request and leaves the flags unchanged.
- R5: In read mode (`rd_mode`=1) with a flag pending, each command raises for exactly one cycle, on the clock after the write, a request to drive ACK (choice 0) or NACK (choice 1) together with one bus action. The command encodings are 01 for repeated start, 10 for next byte and 11 for stop.
- R6: When the acknowledge choice and a command arrive in the same write, the command uses the newly written choice.
- R7: In write mode, command 01 raises only a repeated start and command 11 raises only a stop. Command 10 is ignored: it raises no request and does not consume the flags.
- R8: An accepted command clears both pending flags, so a second command gets no response until the bit engine raises a new event.
- R9: With smart mode on, read mode and a flag pending, a data read (`rd_en`=1, `rd_sel`=1) raises ACK or NACK plus next byte one cycle later and clears the flags.
- R10: A data read raises nothing and keeps the flags when smart mode is off or the mode is write.
- R11: When an accepted command and a smart data read fall in the same cycle, only the command's requests are raised, once. The smart-mode value held before that cycle decides whether the read qualifies.
- R12: When a flag-set event and a flag consumption fall in the same cycle, the flag ends up set.
- R13: `mode_load` loads `mode_is_read` into `rd_mode` on the next clock. Commands in that same cycle still use the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control register write strobe |
| wr_ack_act | input | 1 | Acknowledge choice written (0 ACK, 1 NACK) |
| wr_cmd | input | 2 | Command strobe field written |
| wr_smart_en | input | 1 | Smart-mode enable written |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read select: 0 control word, 1 received data |
| rd_data | output | DATA_W | Read data |
| rx_byte | input | DATA_W | Received byte from the bit engine |
| mb_set | input | 1 | Master-on-bus event pulse |
| sb_set | input | 1 | Slave-on-bus event pulse |
| mode_load | input | 1 | Load transfer direction |
| mode_is_read | input | 1 | Direction to load (1 read) |
| mb_pend | output | 1 | Master-on-bus flag pending |
| sb_pend | output | 1 | Slave-on-bus flag pending |
| rd_mode | output | 1 | Current mode, 1 for master read |
| req_ack | output | 1 | Drive ACK request pulse |
| req_nack | output | 1 | Drive NACK request pulse |
| req_rstart | output | 1 | Repeated start request pulse |
| req_rdnext | output | 1 | Read next byte request pulse |
| req_stop | output | 1 | Stop request pulse |

## Verification
Two functions can land in the same cycle: a command write and a smart-mode data read, which both want the same pending flag. The bench drives both strobes in one cycle with smart mode on, read mode and a flag pending. It expects only the command's NACK-plus-stop pulse, one flag consumption, and nothing in the following cycle. The same bench also makes a flag-set pulse coincide with a consuming command and checks that the flag survives.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_RSTART = 2'b01,
    CMD_RDNEXT = 2'b10,
    CMD_STOP   = 2'b11
  } cmd_e;

  typedef struct packed {
    logic ack;
    logic nack;
    logic rstart;
    logic rdnext;
    logic stop;
  } bus_req_t;

  localparam int CTRL_SMART_BIT = 0;
  localparam int CTRL_CMD_LSB   = 1;
  localparam int CTRL_ACK_BIT   = 3;
  localparam int CTRL_W         = 4;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_ack,
  input  logic wr_smart,
  output logic ack_q,
  output logic smart_q,
  output logic ack_eff
);
  logic ack_d;
  logic smart_d;

  always_comb begin
    ack_d   = ack_q;
    smart_d = smart_q;
    if (wr_en) begin
      ack_d   = wr_ack;
      smart_d = wr_smart;
    end
  end

  // the value written in this access is the one a same-access command uses
  assign ack_eff = ack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      smart_q <= 1'b0;
    end else if (wr_en) begin
      ack_q   <= ack_d;
      smart_q <= smart_d;
    end
  end

  AST_ACK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ack_q == $past(wr_ack)) && (smart_q == $past(wr_smart))); // R3
endmodule

// File: rtl/i2c_flag_track.sv
module i2c_flag_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mb_set,
  input  logic sb_set,
  input  logic consume,
  output logic mb_q,
  output logic sb_q,
  output logic any_flag
);
  logic mb_d;
  logic sb_d;

  // a set event in the consuming cycle wins
  always_comb begin
    mb_d = mb_set | (mb_q & ~consume);
    sb_d = sb_set | (sb_q & ~consume);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q <= 1'b0;
      sb_q <= 1'b0;
    end else begin
      mb_q <= mb_d;
      sb_q <= sb_d;
    end
  end

  assign any_flag = mb_q | sb_q;

  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !mb_set && !sb_set) |=> (!mb_q && !sb_q)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mb_set |=> mb_q); // R12
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_cmd_pkg::*;
(
  input  logic     wr_en,
  input  logic [1:0] wr_cmd,
  input  logic     data_rd,
  input  logic     smart_q,
  input  logic     mode_rd,
  input  logic     any_flag,
  input  logic     ack_eff,
  output bus_req_t req_d,
  output logic     consume
);
  cmd_e cmd;
  logic cmd_ok;
  logic smart_ok;
  logic give_ack;

  always_comb begin
    cmd      = cmd_e'(wr_cmd);
    cmd_ok   = wr_en && (cmd != CMD_NONE) && any_flag
               && !((cmd == CMD_RDNEXT) && !mode_rd);
    smart_ok = !cmd_ok && data_rd && smart_q && mode_rd && any_flag;
    give_ack = (cmd_ok && mode_rd) || smart_ok;

    req_d        = '0;
    req_d.ack    = give_ack && !ack_eff;
    req_d.nack   = give_ack &&  ack_eff;
    req_d.rstart = cmd_ok && (cmd == CMD_RSTART);
    req_d.rdnext = (cmd_ok && (cmd == CMD_RDNEXT)) || smart_ok;
    req_d.stop   = cmd_ok && (cmd == CMD_STOP);
    consume      = cmd_ok || smart_ok;
  end
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ack_act,
  input  logic [1:0]        wr_cmd,
  input  logic              wr_smart_en,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              mb_set,
  input  logic              sb_set,
  input  logic              mode_load,
  input  logic              mode_is_read,
  output logic              mb_pend,
  output logic              sb_pend,
  output logic              rd_mode,
  output logic              req_ack,
  output logic              req_nack,
  output logic              req_rstart,
  output logic              req_rdnext,
  output logic              req_stop
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic     rst_q_n;
  logic     ack_q, smart_q, ack_eff;
  logic     any_flag, consume;
  logic     mode_q, mode_d;
  bus_req_t req_d, req_q;
  logic [CTRL_W-1:0] ctrl_word;

  i2c_rst_sync #(.STAGES(RS_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  i2c_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_ack(wr_ack_act),
    .wr_smart(wr_smart_en), .ack_q(ack_q), .smart_q(smart_q), .ack_eff(ack_eff)
  );

  i2c_flag_track u_flags (
    .clk(clk), .rst_n(rst_q_n), .mb_set(mb_set), .sb_set(sb_set),
    .consume(consume), .mb_q(mb_pend), .sb_q(sb_pend), .any_flag(any_flag)
  );

  i2c_cmd_decode u_dec (
    .wr_en(wr_en), .wr_cmd(wr_cmd), .data_rd(rd_en && rd_sel),
    .smart_q(smart_q), .mode_rd(mode_q), .any_flag(any_flag),
    .ack_eff(ack_eff), .req_d(req_d), .consume(consume)
  );

  always_comb mode_d = mode_load ? mode_is_read : mode_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= 1'b0;
      req_q  <= '0;
    end else begin
      mode_q <= mode_d;
      req_q  <= req_d;
    end
  end

  // command bits are strobes and read as zero
  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[CTRL_ACK_BIT]   = ack_q;
    ctrl_word[CTRL_SMART_BIT] = smart_q;
    ctrl_word[CTRL_CMD_LSB+:2] = 2'b00;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = rd_sel ? rx_byte : {{PAD_W{1'b0}}, ctrl_word};
    end else begin : g_nopad
      assign rd_data = rd_sel ? rx_byte : ctrl_word[DATA_W-1:0];
    end
  endgenerate

  assign rd_mode    = mode_q;
  assign req_ack    = req_q.ack;
  assign req_nack   = req_q.nack;
  assign req_rstart = req_q.rstart;
  assign req_rdnext = req_q.rdnext;
  assign req_stop   = req_q.stop;

  AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(req_ack && req_nack)); // R5
  AST_ONE_BUS_ACTION: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({req_rstart, req_rdnext, req_stop})); // R5
  AST_NO_FLAG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(any_flag) |-> !(req_ack || req_nack || req_rstart || req_rdnext || req_stop)); // R4
  AST_ACK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_ack || req_nack) |-> $past(mode_q)); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_load |=> (rd_mode == $past(mode_is_read))); // R13
endmodule

// File: tb/tb_i2c_cmd_ctrl.sv
module tb_i2c_cmd_ctrl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_ack_act, wr_smart_en, rd_en, rd_sel;
  logic [1:0] wr_cmd;
  logic [DW-1:0] rd_data, rx_byte;
  logic mb_set, sb_set, mode_load, mode_is_read;
  logic mb_pend, sb_pend, rd_mode;
  logic req_ack, req_nack, req_rstart, req_rdnext, req_stop;

  always #4 clk = ~clk;

  i2c_cmd_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ack_act(wr_ack_act),
    .wr_cmd(wr_cmd), .wr_smart_en(wr_smart_en), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rx_byte(rx_byte), .mb_set(mb_set), .sb_set(sb_set),
    .mode_load(mode_load), .mode_is_read(mode_is_read), .mb_pend(mb_pend),
    .sb_pend(sb_pend), .rd_mode(rd_mode), .req_ack(req_ack), .req_nack(req_nack),
    .req_rstart(req_rstart), .req_rdnext(req_rdnext), .req_stop(req_stop)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic mon_on = 1'b0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  // bench model of the requirements
  logic m_ack = 1'b0, m_smart = 1'b0, m_mb = 1'b0, m_sb = 1'b0, m_mode = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected request vector per clock {ack,nack,rstart,rdnext,stop}
  always @(posedge clk) begin
    if (mon_on) begin
      #1;
      if (exp_q.size() != 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({27'd0, req_ack, req_nack, req_rstart, req_rdnext, req_stop}, {27'd0, e}, t);
      end
    end
  end

  // driver: called at a negedge, drives one cycle and pushes the expected result
  task automatic step(input logic we, input logic ack, input logic [1:0] cmd,
                      input logic sm, input logic re, input logic sel,
                      input logic mbs, input logic sbs, input logic ml,
                      input logic mr, input string tag);
    logic flag, cok, sok, aeff, gack;
    wr_en = we; wr_ack_act = ack; wr_cmd = cmd; wr_smart_en = sm;
    rd_en = re; rd_sel = sel; mb_set = mbs; sb_set = sbs;
    mode_load = ml; mode_is_read = mr;
    flag = m_mb | m_sb;
    cok  = we && (cmd != 2'b00) && flag && !((cmd == 2'b10) && !m_mode);
    sok  = !cok && re && sel && m_smart && m_mode && flag;
    aeff = we ? ack : m_ack;
    gack = (cok && m_mode) || sok;
    exp_q.push_back({gack && !aeff, gack && aeff, cok && cmd == 2'b01,
                     (cok && cmd == 2'b10) || sok, cok && cmd == 2'b11});
    tag_q.push_back(tag);
    if (we) begin m_ack = ack; m_smart = sm; end
    m_mb = mbs | (m_mb & !(cok | sok));
    m_sb = sbs | (m_sb & !(cok | sok));
    if (ml) m_mode = mr;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_cmd = 0; rd_en = 0; mb_set = 0; sb_set = 0; mode_load = 0;
  endtask

  task automatic idle(input string tag);
    step(0, m_ack, 2'b00, m_smart, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic chk_flags(input string tag);
    chk({30'd0, mb_pend, sb_pend}, {30'd0, m_mb, m_sb}, tag);
  endtask

  task automatic chk_ctrl(input string tag);
    rd_sel = 0;
    #1;
    chk({24'd0, rd_data}, {24'd0, 4'h0, m_ack, 2'b00, m_smart}, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    wr_en = 0; wr_ack_act = 0; wr_cmd = 0; wr_smart_en = 0; rd_en = 0; rd_sel = 0;
    rx_byte = 8'hA5; mb_set = 0; sb_set = 0; mode_load = 0; mode_is_read = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    mon_on = 1;

    // R1 reset state
    chk_ctrl("R1 ctrl readback");
    chk_flags("R1 flags");
    chk({31'd0, rd_mode}, 32'd0, "R1 mode");
    idle("R1 no request");

    // R2 data path select
    rd_sel = 1; #1;
    chk({24'd0, rd_data}, 32'hA5, "R2 data readback");

    // R4 / R3: command without flag rejected, ack write still lands
    step(1, 1, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R4 rejected command");
    chk_ctrl("R3 ack written while rejected, R2 cmd reads zero");
    chk_flags("R4 flags unchanged");

    // R13 mode load
    step(0, m_ack, 2'b00, m_smart, 0, 0, 0, 0, 1, 1, "R13 mode load");
    chk({31'd0, rd_mode}, 32'd1, "R13 rd_mode");

    // R5 read mode commands
    step(0, m_ack, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R5 mb event");
    chk_flags("R5 mb pending");
    step(1, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R5 ack plus rstart");
    idle("R5 pulse is one cycle");
    chk_flags("R8 flags consumed");
    step(1, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R8 second command ignored");
    step(0, m_ack, 2'b00, 0, 0, 0, 0, 1, 0, 0, "R6 sb event");
    step(1, 1, 2'b10, 0, 0, 0, 0, 0, 0, 0, "R6 new nack used, next byte");
    step(0, m_ack, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R5 mb event");
    step(1, 0, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R5 ack plus stop");
    idle("R5 idle");

    // R7 write mode
    step(0, m_ack, 2'b00, 0, 0, 0, 1, 0, 1, 0, "R7 to write mode, mb event");
    step(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, 0, "R7 next byte ignored");
    chk_flags("R7 flag kept");
    step(1, 1, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R7 rstart only");
    step(0, m_ack, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R7 mb event");
    step(1, 0, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R7 stop only");
    idle("R7 idle");

    // R9 / R10 smart mode
    step(1, 1, 2'b00, 1, 0, 0, 1, 0, 1, 1, "R9 smart on, read mode, event");
    chk_ctrl("R3 smart readback");
    step(0, m_ack, 2'b00, m_smart, 1, 1, 0, 0, 0, 0, "R9 smart read nack next byte");
    idle("R9 idle");
    chk_flags("R9 flags consumed");
    step(0, m_ack, 2'b00, m_smart, 1, 1, 0, 0, 0, 0, "R10 smart read no flag");
    step(0, m_ack, 2'b00, m_smart, 0, 0, 1, 0, 1, 0, "R10 write mode, event");
    step(0, m_ack, 2'b00, m_smart, 1, 1, 0, 0, 0, 0, "R10 smart read in write mode");
    chk_flags("R10 flag kept");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 1, 1, "R10 smart off, read mode");
    step(0, m_ack, 2'b00, 0, 1, 1, 0, 0, 0, 0, "R10 read with smart off");
    chk_flags("R10 flag kept smart off");
    step(0, m_ack, 2'b00, 0, 1, 0, 0, 0, 0, 0, "R10 control read no effect");

    // R11 command and smart read in the same cycle
    step(1, 0, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R11 smart on");
    step(1, 1, 2'b11, 1, 1, 1, 0, 0, 0, 0, "R11 only nack plus stop");
    idle("R11 nothing follows");
    chk_flags("R11 single consumption");

    // R12 set and consume together
    step(0, m_ack, 2'b00, m_smart, 0, 0, 1, 0, 0, 0, "R12 mb event");
    step(1, 0, 2'b01, 1, 0, 0, 1, 1, 0, 0, "R12 command with new events");
    chk_flags("R12 flags survive");
    idle("R12 idle");
    idle("R12 drain");

    mon_on = 0;
    finish_run();
  end
endmodule